// File: doc/BRIEF.md
# Greyscale Temporal-Dither Pixel Modulator

This block turns a small frame of 8-bit grey levels into a sequence of one-bit-per-pixel frames. Shown in quick succession on a black-and-white display, these frames average out to the grey levels. Each pixel holds a signed 8-bit phase and an 8-bit grey value. The pixel's output bit comes from the sign of its phase. The phase is then pulled down by half its range when it is non-negative, and the grey value is added. The result is written back, so each pixel behaves as a first-order sigma-delta modulator rather than a fixed pulse-width pattern.

A start pulse begins one frame pass. The block visits the pixels in storage order, one pixel per clock. It packs each run of eight pixel bits into a byte and offers the byte on a valid/ready interface to a downstream serial display link, which sends it as display data. After the last byte of the pass is taken, the block raises a one-cycle done pulse. Between passes a host loads grey values and phases through a simple write port.

Top module: `grey_dither_mod`

## Requirements
- R1: After reset `pix_valid` and `done` are low and every phase and grey value is zero. A pass right after reset therefore yields all-zero bytes, and the following pass yields all-one bytes.
- R2: A pixel whose phase, read as signed 8-bit, is non-negative contributes bit 0. A pixel whose phase is negative contributes bit 1.
- R3: During a pass each pixel's phase is replaced by (phase with bit 7 forced to 1) + grey, modulo 256. The forcing of bit 7 matters only when the phase was non-negative. The new phase is the one read on the next pass.
- R4: Output byte k of a pass covers pixels 8k to 8k+7. Pixel 8k sits in bit 7 and pixel 8k+7 in bit 0. Bytes leave in increasing k.
- R5: A `start` pulse while idle begins a pass that yields exactly NUM_BLOCKS bytes. A `start` during a pass has no effect, and no byte is offered once the pass has ended.
- R6: While `pix_valid` is high and `pix_ready` is low, `pix_valid` stays high and `pix_byte` holds its value.
- R7: `done` is high for exactly the one cycle after the handshake of the last byte of a pass, and at no other time.
- R8: A host write with `host_we` high stores `host_data` into the pixel at index `host_addr`. It goes to the grey value when `host_sel` is 0 and to the phase when `host_sel` is 1. A host write issued while a pass is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse to begin a frame pass |
| done | output | 1 | One-cycle pulse after the last byte of a pass is taken |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 1 | 0 writes the grey value, 1 writes the phase |
| host_addr | input | PIX_AW | Pixel index for the host write |
| host_data | input | 8 | Host write data |
| pix_valid | output | 1 | Packed byte on offer |
| pix_ready | input | 1 | Downstream accepts the byte |
| pix_byte | output | 8 | Eight packed pixel bits, first pixel in bit 7 |

## Verification
The bench builds the block with NUM_BLOCKS set to 2, which gives sixteen pixels and two bytes per pass. A single pass therefore covers both the step between blocks and the last-block handshake that raises done. Eight pixel vectors with hand-worked four-pass bit sequences are mirrored across the two blocks. They reach the sign edges at 0x7F, 0x80, 0xFF and 0x00 and show the phase wrapping modulo 256. Directed passes add back-pressure, host writes and start pulses issued mid-pass, and a reset after the phases have gone negative.

// File: rtl/gdm_pkg.sv
// Shared constants and the per-pixel phase step used by the modulator.
// Assumes 8-bit phases and grey values and eight pixels per output byte.
package gdm_pkg;
    localparam int unsigned VAL_W    = 8;
    localparam int unsigned BYTE_PIX = 8;
    localparam int unsigned SUB_W    = $clog2(BYTE_PIX);

    typedef logic [VAL_W-1:0] val_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_OFFER = 2'd2
    } seq_state_t;
endpackage

// File: rtl/gdm_phase_unit.sv
// Combinational sigma-delta step for one pixel: the sign of the phase gives
// the bit; a non-negative phase gets bit 7 forced (minus 128) before the
// grey value is added modulo 256. Assumes two's-complement 8-bit phases.
module gdm_phase_unit
    import gdm_pkg::*;
(
    input  val_t phase_in,
    input  val_t grey_in,
    output logic bit_out,
    output val_t phase_out
);
    val_t adj;

    // Pick the output bit and pull a non-negative phase down by half range.
    always_comb begin
        bit_out   = phase_in[VAL_W-1];
        adj       = phase_in | val_t'(1 << (VAL_W-1));
        phase_out = adj + grey_in;
    end
endmodule

// File: rtl/gdm_pixel_store.sv
// Per-pixel phase and grey storage with an asynchronous read port, one
// engine phase write port and one host write port. Assumes the caller
// gates host writes so they never meet an engine write.
module gdm_pixel_store
    import gdm_pkg::*;
#(
    parameter int unsigned NPIX = 32,
    parameter int unsigned AW   = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_idx,
    output val_t          rd_phase,
    output val_t          rd_grey,
    input  logic          eng_we,
    input  val_t          eng_phase,
    input  logic          host_we,
    input  logic          host_sel,
    input  logic [AW-1:0] host_idx,
    input  val_t          host_data
);
    val_t phase_mem [NPIX];
    val_t grey_mem  [NPIX];
    logic host_ok;

    // Drop host writes that point past the last pixel.
    always_comb host_ok = host_we && (32'(host_idx) < NPIX);

    // Read both values of the pixel the engine is working on.
    always_comb begin
        rd_phase = phase_mem[rd_idx];
        rd_grey  = grey_mem[rd_idx];
    end

    // Phase storage: cleared by reset, written by the engine or the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NPIX; i++) phase_mem[i] <= '0;
        end else if (eng_we) begin
            phase_mem[rd_idx] <= eng_phase;
        end else if (host_ok && host_sel) begin
            phase_mem[host_idx] <= host_data;
        end
    end

    // Grey storage: cleared by reset, written only by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NPIX; i++) grey_mem[i] <= '0;
        end else if (host_ok && !host_sel) begin
            grey_mem[host_idx] <= host_data;
        end
    end
endmodule

// File: rtl/gdm_byte_packer.sv
// Shift register that collects pixel bits, the earliest one ending up in
// the most significant position. Assumes exactly eight shifts per byte.
module gdm_byte_packer
    import gdm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic shift_en,
    input  logic bit_in,
    output val_t byte_out
);
    val_t sr;

    // Shift each new pixel bit in at the bottom.
    always_ff @(posedge clk) begin
        if (!rst_n)        sr <= '0;
        else if (shift_en) sr <= {sr[VAL_W-2:0], bit_in};
    end

    assign byte_out = sr;
endmodule

// File: rtl/grey_dither_mod.sv
// Frame-pass sequencer for the temporal-dither modulator. It processes one
// pixel per cycle, writes each new phase back in the same cycle, and
// offers one packed byte per block of eight. It stalls on pix_ready.
// Assumes start and host writes are sampled only while idle.
module grey_dither_mod
    import gdm_pkg::*;
#(
    parameter int unsigned NUM_BLOCKS = 4,
    localparam int unsigned BLK_W  = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
    localparam int unsigned PIX_AW = BLK_W + SUB_W,
    localparam int unsigned NPIX   = NUM_BLOCKS * BYTE_PIX
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              done,
    input  logic              host_we,
    input  logic              host_sel,
    input  logic [PIX_AW-1:0] host_addr,
    input  logic [VAL_W-1:0]  host_data,
    output logic              pix_valid,
    input  logic              pix_ready,
    output logic [VAL_W-1:0]  pix_byte
);
    seq_state_t       st;
    logic [BLK_W-1:0] blk;
    logic [SUB_W-1:0] sub;
    logic             last_blk;
    logic             run_now;
    val_t             cur_phase, cur_grey, new_phase;
    logic             cur_bit;

    assign run_now  = (st == ST_RUN);
    assign last_blk = (blk == BLK_W'(NUM_BLOCKS - 1));

    gdm_pixel_store #(.NPIX(NPIX), .AW(PIX_AW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    ({blk, sub}),
        .rd_phase  (cur_phase),
        .rd_grey   (cur_grey),
        .eng_we    (run_now),
        .eng_phase (new_phase),
        .host_we   (host_we && (st == ST_IDLE)),
        .host_sel  (host_sel),
        .host_idx  (host_addr),
        .host_data (host_data)
    );

    gdm_phase_unit u_step (
        .phase_in  (cur_phase),
        .grey_in   (cur_grey),
        .bit_out   (cur_bit),
        .phase_out (new_phase)
    );

    gdm_byte_packer u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (run_now),
        .bit_in   (cur_bit),
        .byte_out (pix_byte)
    );

    // Step through idle, eight pixel cycles, then byte offer; pulse done at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            blk  <= '0;
            sub  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        st  <= ST_RUN;
                        blk <= '0;
                        sub <= '0;
                    end
                end
                ST_RUN: begin
                    sub <= sub + 1'b1;
                    if (sub == SUB_W'(BYTE_PIX - 1)) st <= ST_OFFER;
                end
                ST_OFFER: begin
                    if (pix_ready) begin
                        if (last_blk) begin
                            st   <= ST_IDLE;
                            done <= 1'b1;
                        end else begin
                            blk <= blk + 1'b1;
                            st  <= ST_RUN;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign pix_valid = (st == ST_OFFER);
endmodule

// File: rtl/gdm_checker.sv
// Port-level protocol checks for the modulator, bound to the top module.
module gdm_checker #(
    parameter int unsigned NUM_BLOCKS = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       done,
    input logic       pix_valid,
    input logic       pix_ready,
    input logic [7:0] pix_byte
);
    int unsigned hs_cnt;

    // Count byte handshakes since the last done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)                      hs_cnt <= 0;
        else if (done)                   hs_cnt <= (pix_valid && pix_ready) ? 1 : 0;
        else if (pix_valid && pix_ready) hs_cnt <= hs_cnt + 1;
    end

    AST_OFFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && !pix_ready |=> pix_valid && $stable(pix_byte)); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_DONE_AFTER_HS: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(pix_valid && pix_ready)); // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !pix_valid); // R5
    AST_BYTE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> hs_cnt == NUM_BLOCKS); // R5
    AST_NO_EXTRA_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        hs_cnt <= NUM_BLOCKS); // R5
endmodule

bind grey_dither_mod gdm_checker #(.NUM_BLOCKS(NUM_BLOCKS)) u_gdm_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .pix_valid (pix_valid),
    .pix_ready (pix_ready),
    .pix_byte  (pix_byte)
);

// File: tb/grey_dither_mod_bench.sv
module grey_dither_mod_bench;
    localparam int unsigned NB = 2;
    localparam int unsigned AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          done;
    logic          host_we = 1'b0;
    logic          host_sel = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [7:0]    host_data = '0;
    logic          pix_valid;
    logic          pix_ready = 1'b0;
    logic [7:0]    pix_byte;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] got [NB];

    // Vector: phase[19:12], grey[11:4], bits of passes 1..4 in [3:0] (pass 1 = bit 3).
    localparam logic [19:0] VEC [8] = '{
        {8'h00, 8'h00, 4'b0111},
        {8'h00, 8'h80, 4'b0000},
        {8'h00, 8'h40, 4'b0101},
        {8'h80, 8'hFF, 4'b1011},
        {8'h7F, 8'h01, 4'b0011},
        {8'hFF, 8'h7F, 4'b1000},
        {8'h40, 8'hC0, 4'b0101},
        {8'h01, 8'h80, 4'b0000}
    };

    grey_dither_mod #(.NUM_BLOCKS(NB)) u_grey_dither_mod (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done),
        .host_we(host_we), .host_sel(host_sel), .host_addr(host_addr),
        .host_data(host_data), .pix_valid(pix_valid), .pix_ready(pix_ready),
        .pix_byte(pix_byte)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic sel, input int idx, input logic [7:0] d);
        @(negedge clk);
        host_we = 1'b1; host_sel = sel; host_addr = AW'(idx); host_data = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    // One pass; hold = cycles to stall each byte. mid_write pokes host port while block 0 waits.
    task automatic run_pass(input int hold, input bit mid_write);
        logic [7:0] snap;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int b = 0; b < NB; b++) begin
            while (!pix_valid) @(negedge clk);
            snap = pix_byte;
            if (b == 0 && mid_write) begin
                start = 1'b1;                      // R5: start during pass ignored
                host_we = 1'b1; host_sel = 1'b1; host_addr = 0; host_data = 8'h00;
                @(negedge clk);
                start = 1'b0;
                host_sel = 1'b0; host_addr = 1; host_data = 8'h80;
                @(negedge clk);
                host_we = 1'b0;
            end
            if (hold > 0) begin
                repeat (hold) @(negedge clk);
                check("R6 valid held", 32'(pix_valid), 32'd1);
                check("R6 byte held", 32'(pix_byte), 32'(snap));
            end
            got[b] = pix_byte;
            pix_ready = 1'b1;
            @(negedge clk);
            pix_ready = 1'b0;
            check("R7 done timing", 32'(done), (b == NB - 1) ? 32'd1 : 32'd0);
        end
        @(negedge clk);
        check("R7 done single", 32'(done), 32'd0);
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 valid after reset", 32'(pix_valid), 32'd0);
        check("R1 done after reset", 32'(done), 32'd0);
        rst_n = 1'b1;

        // Load table: block 0 pixel i = vector i, block 1 pixel i = vector 7-i (R8).
        for (int i = 0; i < 8; i++) begin
            host_write(1'b0, i, VEC[i][11:4]);
            host_write(1'b1, i, VEC[i][19:12]);
            host_write(1'b0, 8 + i, VEC[7 - i][11:4]);
            host_write(1'b1, 8 + i, VEC[7 - i][19:12]);
        end

        // Four passes walking the vector table (R2, R3, R4).
        for (int p = 0; p < 4; p++) begin
            logic [7:0] e0, e1;
            run_pass(p, 1'b0);
            for (int i = 0; i < 8; i++) begin
                e0[7 - i] = VEC[i][3 - p];
                e1[7 - i] = VEC[7 - i][3 - p];
            end
            check("R2 R3 R4 block0", 32'(got[0]), 32'(e0));
            check("R2 R3 R4 block1", 32'(got[1]), 32'(e1));
        end

        // R1: reset clears phases and greys.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        host_write(1'b0, 0, 8'h40);
        run_pass(2, 1'b1);
        check("R1 first pass after reset b0", 32'(got[0]), 32'h00);
        check("R1 first pass after reset b1", 32'(got[1]), 32'h00);
        repeat (10) @(negedge clk);
        check("R5 no byte after pass", 32'(pix_valid), 32'd0);
        // R8: mid-pass writes to pixel 0 phase and pixel 1 grey were ignored.
        run_pass(0, 1'b0);
        check("R1 R8 second pass b0", 32'(got[0]), 32'hFF);
        check("R1 second pass b1", 32'(got[1]), 32'hFF);
        run_pass(1, 1'b0);
        check("R8 R3 third pass b0", 32'(got[0]), 32'h7F);
        check("R3 third pass b1", 32'(got[1]), 32'hFF);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule